// File: doc/BRIEF.md
# Key-Combination Reset Generator

This block gives a system a way out of a hung state: when the user holds a chosen set of keys together for long enough, a hardware reset pulse is produced. It takes a stream of key events, where each event carries an 8-bit code and says whether that key went down or came up. Two independent channels compare the set of keys currently held against their own programmed codes. Channel 1 has three code slots and channel 2 has two. A slot programmed to zero is unused, so a channel can require fewer keys than it has slots.

When a channel's whole combination is held, a qualification timer starts. This timer runs on a prescaled tick. If any required key is released before the programmed hold time ends, the timer starts again from zero. Once the hold time is met, the channel drives an active-low reset pulse of programmable width on its own output. It then waits until the combination is released before it can fire again.

Channel 1 can also pass an external active-low reset straight through to its output. The configuration fields are plain inputs and are expected to stay stable while the block runs, with a reset applied after any change.

Top module: `key_combo_reset_gen`

## Requirements
- R1: After rst_n is deasserted, with no events and pass_en low, rst1_n and rst2_n are both 1.
- R2: rst1_n pulses low only when every nonzero code among ch1_code_a, ch1_code_b and ch1_code_c is held at the same time. A code is held from an event with ev_press=1 until an event with ev_press=0 for that code.
- R3: Channel 2 uses only ch2_code_a and ch2_code_b, drives only rst2_n, and works independently of channel 1.
- R4: A slot set to code 0x00 is ignored in the match, and an event with code 0x00 never counts. A channel whose slots are all zero never fires.
- R5: With TICK_DIV=4 and HOLD_STEP=2, rst goes low right after the clock edge that lies hold_sel*8+2 edges after the edge that sampled the event completing the combination. hold_sel=0 is immediate, which gives 2 edges.
- R6: If a required key is released during qualification, qualification is abandoned. The delay is then counted again from the event that completes the combination anew.
- R7: With PULSE_STEP=2, the reset output stays low for (width_sel+1)*8+1 clock cycles.
- R8: One hold gives exactly one pulse. A channel fires again only after its combination has been broken and then formed again.
- R9: When pass_en=1 and ext_rst_n=0, rst1_n is 0 whatever channel 1 is doing. When pass_en=0, ext_rst_n has no effect on either output. rst2_n never follows ext_rst_n.
- R10: Events are accepted only when ev_valid=1. Events for codes outside a channel's slots do not change that channel's match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_valid | input | 1 | Event present this cycle |
| ev_code | input | 8 | Event key code |
| ev_press | input | 1 | 1 = key down, 0 = key up |
| ch1_code_a | input | 8 | Channel 1 slot A code (0 = unused) |
| ch1_code_b | input | 8 | Channel 1 slot B code (0 = unused) |
| ch1_code_c | input | 8 | Channel 1 slot C code (0 = unused) |
| ch2_code_a | input | 8 | Channel 2 slot A code (0 = unused) |
| ch2_code_b | input | 8 | Channel 2 slot B code (0 = unused) |
| hold_sel | input | 3 | Hold-time code, 0 = immediate |
| width_sel | input | 2 | Pulse-width code |
| pass_en | input | 1 | Route ext_rst_n onto rst1_n |
| ext_rst_n | input | 1 | External active-low reset |
| rst1_n | output | 1 | Channel 1 reset, active low |
| rst2_n | output | 1 | Channel 2 reset, active low |

## Verification
The assertions check on every cycle that the pass-through forces or leaves rst1_n as R9 requires, and that channel 2's output goes low only during its own pulse. They also check that a pulse starts only from a held combination and that a locked channel cannot pulse again while the combination stays held. The exact hold delay, the pulse width, the restart after a key drops out and the one-pulse-per-hold behaviour depend on counts over many cycles. Only the bench shows these, through a cycle-level reference model and directed delay and width measurements.

// File: rtl/krg_pkg.sv
// Package: shared types and time-table helpers for the key-combination
// reset generator. Assumes codes are 8 bits and 0 means "slot unused".
package krg_pkg;

    localparam int EV_W = 8;

    // Channel sequencing states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for the full combination
        ST_QUAL = 2'd1,   // combination held, hold timer running
        ST_FIRE = 2'd2,   // reset pulse being driven
        ST_LOCK = 2'd3    // waiting for the combination to be released
    } chan_state_t;

    // Hold-time code to tick count (code 0 = no qualification)
    function automatic int hold_ticks(input int code, input int step);
        return code * step;
    endfunction

    // Pulse-width code to tick count
    function automatic int pulse_ticks(input int code, input int step);
        return (code + 1) * step;
    endfunction

endpackage

// File: rtl/krg_tick_timer.sv
// Module: tick timer. A prescaler divides the clock by TICK_DIV and a tick
// counter climbs to `limit`, then stops there and holds `done` high.
// Assumes `limit` stays stable while the timer runs; `clr` restarts it.
module krg_tick_timer #(
    parameter int TICK_DIV = 4,
    parameter int CNT_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);
    localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;

    // Advance the prescaler and count ticks until the limit is reached
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (cnt_q != limit) begin
            if (pre_q == PRE_LAST) begin
                pre_q <= '0;
                cnt_q <= cnt_q + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    // Limit reached
    assign done = (cnt_q == limit);

endmodule

// File: rtl/krg_combo_match.sv
// Module: combination matcher. Each slot keeps a held flag for its code,
// set by a key-down event and cleared by a key-up event. `combo` is high
// when every used slot is held and at least one slot is used.
// Assumes slot codes stay stable between resets.
module krg_combo_match #(
    parameter int NSLOT = 3,
    parameter int EV_W  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ev_valid,
    input  logic [EV_W-1:0]            ev_code,
    input  logic                       ev_press,
    input  logic [NSLOT-1:0][EV_W-1:0] slot_code,
    output logic                       combo
);
    logic [NSLOT-1:0] used;
    logic [NSLOT-1:0] held_q;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        // A slot takes part only when its code is nonzero
        assign used[s] = (slot_code[s] != '0);

        // Track whether this slot's key is currently down
        always_ff @(posedge clk) begin
            if (!rst_n || !used[s]) begin
                held_q[s] <= 1'b0;
            end else if (ev_valid && ev_code == slot_code[s]) begin
                held_q[s] <= ev_press;
            end
        end
    end

    // All used slots held, and at least one used
    assign combo = (&(held_q | ~used)) && (|used);

endmodule

// File: rtl/krg_channel.sv
// Module: one reset channel. It qualifies the matched combination over the
// hold time, fires a pulse of the chosen width, then locks until the
// combination is released. Assumes hold/width limits are stable while running.
module krg_channel
    import krg_pkg::*;
#(
    parameter int NSLOT    = 3,
    parameter int TICK_DIV = 4,
    parameter int CNT_W    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ev_valid,
    input  logic [EV_W-1:0]            ev_code,
    input  logic                       ev_press,
    input  logic [NSLOT-1:0][EV_W-1:0] slot_code,
    input  logic [CNT_W-1:0]           hold_limit,
    input  logic [CNT_W-1:0]           pulse_limit,
    output logic                       pulse,
    output logic                       combo,
    output logic                       locked
);
    chan_state_t st_q;
    logic        hold_done;
    logic        pulse_done;
    logic        hold_clr;
    logic        pulse_clr;

    krg_combo_match #(
        .NSLOT (NSLOT),
        .EV_W  (EV_W)
    ) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_valid  (ev_valid),
        .ev_code   (ev_code),
        .ev_press  (ev_press),
        .slot_code (slot_code),
        .combo     (combo)
    );

    // Timers run only in their own state
    assign hold_clr  = (st_q != ST_QUAL);
    assign pulse_clr = (st_q != ST_FIRE);

    krg_tick_timer #(
        .TICK_DIV (TICK_DIV),
        .CNT_W    (CNT_W)
    ) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (hold_clr),
        .limit (hold_limit),
        .done  (hold_done)
    );

    krg_tick_timer #(
        .TICK_DIV (TICK_DIV),
        .CNT_W    (CNT_W)
    ) u_width (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pulse_clr),
        .limit (pulse_limit),
        .done  (pulse_done)
    );

    // Channel sequencing: idle -> qualify -> fire -> lock -> idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: if (combo) st_q <= ST_QUAL;
                ST_QUAL: begin
                    if (!combo)         st_q <= ST_IDLE;
                    else if (hold_done) st_q <= ST_FIRE;
                end
                ST_FIRE: if (pulse_done) st_q <= ST_LOCK;
                ST_LOCK: if (!combo) st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // State decodes
    assign pulse  = (st_q == ST_FIRE);
    assign locked = (st_q == ST_LOCK);

endmodule

// File: rtl/key_combo_reset_gen.sv
// Module: key-combination reset generator, top level. Two channels watch a
// shared key-event stream. Channel 1 has three slots and may pass an
// external reset through. Channel 2 has two slots. Outputs are active low.
// Assumes configuration inputs change only while rst_n is asserted.
module key_combo_reset_gen
    import krg_pkg::*;
#(
    parameter int TICK_DIV   = 4,
    parameter int HOLD_STEP  = 2,
    parameter int PULSE_STEP = 2,
    parameter int CNT_W      = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ev_valid,
    input  logic [EV_W-1:0] ev_code,
    input  logic            ev_press,
    input  logic [EV_W-1:0] ch1_code_a,
    input  logic [EV_W-1:0] ch1_code_b,
    input  logic [EV_W-1:0] ch1_code_c,
    input  logic [EV_W-1:0] ch2_code_a,
    input  logic [EV_W-1:0] ch2_code_b,
    input  logic [2:0]      hold_sel,
    input  logic [1:0]      width_sel,
    input  logic            pass_en,
    input  logic            ext_rst_n,
    output logic            rst1_n,
    output logic            rst2_n
);
    localparam int NSLOT1 = 3;
    localparam int NSLOT2 = 2;

    logic [CNT_W-1:0] hold_limit;
    logic [CNT_W-1:0] pulse_limit;
    logic [NSLOT1-1:0][EV_W-1:0] slots1;
    logic [NSLOT2-1:0][EV_W-1:0] slots2;
    logic c1_pulse, c1_combo, c1_lock;
    logic c2_pulse, c2_combo, c2_lock;

    // Translate the time codes into tick counts
    assign hold_limit  = CNT_W'(hold_ticks(int'(hold_sel), HOLD_STEP));
    assign pulse_limit = CNT_W'(pulse_ticks(int'(width_sel), PULSE_STEP));

    // Gather slot codes per channel
    assign slots1 = {ch1_code_c, ch1_code_b, ch1_code_a};
    assign slots2 = {ch2_code_b, ch2_code_a};

    krg_channel #(
        .NSLOT    (NSLOT1),
        .TICK_DIV (TICK_DIV),
        .CNT_W    (CNT_W)
    ) u_ch1 (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_valid    (ev_valid),
        .ev_code     (ev_code),
        .ev_press    (ev_press),
        .slot_code   (slots1),
        .hold_limit  (hold_limit),
        .pulse_limit (pulse_limit),
        .pulse       (c1_pulse),
        .combo       (c1_combo),
        .locked      (c1_lock)
    );

    krg_channel #(
        .NSLOT    (NSLOT2),
        .TICK_DIV (TICK_DIV),
        .CNT_W    (CNT_W)
    ) u_ch2 (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_valid    (ev_valid),
        .ev_code     (ev_code),
        .ev_press    (ev_press),
        .slot_code   (slots2),
        .hold_limit  (hold_limit),
        .pulse_limit (pulse_limit),
        .pulse       (c2_pulse),
        .combo       (c2_combo),
        .locked      (c2_lock)
    );

    // Active-low outputs; channel 1 also ORs in the external reset
    assign rst1_n = !(c1_pulse || (pass_en && !ext_rst_n));
    assign rst2_n = !c2_pulse;

endmodule

// File: rtl/krg_checker.sv
// Module: assertion checker for key_combo_reset_gen, bound to the top.
module krg_checker (
    input logic clk,
    input logic rst_n,
    input logic pass_en,
    input logic ext_rst_n,
    input logic rst1_n,
    input logic rst2_n,
    input logic c1_pulse,
    input logic c1_combo,
    input logic c1_lock,
    input logic c2_pulse,
    input logic c2_combo,
    input logic c2_lock
);
    // R9
    pass_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_en && !ext_rst_n) |-> !rst1_n);

    // R9
    pass_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pass_en && !c1_pulse) |-> rst1_n);

    // R3
    ch2_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !c2_pulse |-> rst2_n);

    // R2
    ch1_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c1_pulse) |-> $past(c1_combo));

    // R3
    ch2_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c2_pulse) |-> $past(c2_combo));

    // R8
    ch1_relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c1_lock && c1_combo) |=> !c1_pulse);

    // R8
    ch2_relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c2_lock && c2_combo) |=> !c2_pulse);

    // R7
    ch2_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(c2_pulse) |-> c2_lock);

endmodule

bind key_combo_reset_gen krg_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pass_en   (pass_en),
    .ext_rst_n (ext_rst_n),
    .rst1_n    (rst1_n),
    .rst2_n    (rst2_n),
    .c1_pulse  (c1_pulse),
    .c1_combo  (c1_combo),
    .c1_lock   (c1_lock),
    .c2_pulse  (c2_pulse),
    .c2_combo  (c2_combo),
    .c2_lock   (c2_lock)
);

// File: tb/tb_key_combo_reset_gen.sv
module tb_key_combo_reset_gen;
    localparam int TD = 4;
    localparam int HS = 2;
    localparam int PS = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_valid = 1'b0;
    logic [7:0] ev_code = 8'h00;
    logic       ev_press = 1'b0;
    logic [7:0] c1a = 8'h11, c1b = 8'h22, c1c = 8'h33;
    logic [7:0] c2a = 8'h44, c2b = 8'h55;
    logic [2:0] hold_sel = 3'd1;
    logic [1:0] width_sel = 2'd0;
    logic       pass_en = 1'b0;
    logic       ext_rst_n = 1'b1;
    logic       rst1_n, rst2_n;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    chk_en = 1'b0;

    // Reference model state
    bit held_m[256];
    int st_m[2];
    int cnt_m[2];

    always #4 clk = ~clk;

    key_combo_reset_gen dut (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_code(ev_code),
        .ev_press(ev_press), .ch1_code_a(c1a), .ch1_code_b(c1b),
        .ch1_code_c(c1c), .ch2_code_a(c2a), .ch2_code_b(c2b),
        .hold_sel(hold_sel), .width_sel(width_sel), .pass_en(pass_en),
        .ext_rst_n(ext_rst_n), .rst1_n(rst1_n), .rst2_n(rst2_n)
    );

    function automatic int hold_cyc();
        return int'(hold_sel) * HS * TD;
    endfunction

    function automatic int pulse_cyc();
        return (int'(width_sel) + 1) * PS * TD;
    endfunction

    function automatic bit combo_m(input int ch);
        logic [7:0] cs[3];
        int used = 0;
        bit ok = 1'b1;
        cs[0] = (ch == 0) ? c1a : c2a;
        cs[1] = (ch == 0) ? c1b : c2b;
        cs[2] = (ch == 0) ? c1c : 8'h00;
        for (int k = 0; k < 3; k++) begin
            if (cs[k] != 8'h00) begin
                used++;
                if (!held_m[cs[k]]) ok = 1'b0;
            end
        end
        return ok && (used > 0);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Cycle model, then compare just after the edge
    always @(posedge clk) begin
        bit cb[2];
        bit e1, e2;
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) held_m[i] = 1'b0;
            st_m[0] = 0; st_m[1] = 0; cnt_m[0] = 0; cnt_m[1] = 0;
        end else begin
            cb[0] = combo_m(0);
            cb[1] = combo_m(1);
            if (ev_valid) held_m[ev_code] = ev_press;
            for (int ch = 0; ch < 2; ch++) begin
                case (st_m[ch])
                    0: if (cb[ch]) begin st_m[ch] = 1; cnt_m[ch] = 0; end
                    1: begin
                        if (!cb[ch]) st_m[ch] = 0;
                        else if (cnt_m[ch] == hold_cyc()) begin st_m[ch] = 2; cnt_m[ch] = 0; end
                        else cnt_m[ch]++;
                    end
                    2: if (cnt_m[ch] == pulse_cyc()) st_m[ch] = 3; else cnt_m[ch]++;
                    default: if (!cb[ch]) st_m[ch] = 0;
                endcase
            end
        end
        #2;
        if (chk_en) begin
            e1 = !((st_m[0] == 2) || (pass_en && !ext_rst_n));
            e2 = !(st_m[1] == 2);
            check(rst1_n == e1, cur_req, "rst1_n model", int'(rst1_n), int'(e1));
            check(rst2_n == e2, cur_req, "rst2_n model", int'(rst2_n), int'(e2));
        end
    end

    task automatic apply_reset(input logic [2:0] h, input logic [1:0] w);
        @(negedge clk);
        rst_n = 1'b0; hold_sel = h; width_sel = w;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic key(input logic [7:0] code, input bit p);
        @(negedge clk);
        ev_valid = 1'b1; ev_code = code; ev_press = p;
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    function automatic logic out_of(input int which);
        return (which == 1) ? rst1_n : rst2_n;
    endfunction

    // Called right after key(); measures delay to low, then low width
    task automatic measure(input int which, input int exp_d, input int exp_w,
                           input string req);
        int d = 0;
        int w = 0;
        while (out_of(which) && d < 300) begin @(negedge clk); d++; end
        check(d == exp_d, req, "delay to pulse", d, exp_d);
        while (!out_of(which) && w < 300) begin @(negedge clk); w++; end
        check(w == exp_w, req, "pulse width", w, exp_w);
    endtask

    task automatic watch_high(input int which, input int n, input string req);
        int lows = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!out_of(which)) lows++;
        end
        check(lows == 0, req, "cycles low when none expected", lows, 0);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int pulses;
        logic prev;
        logic [7:0] pool[8];
        pool = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h99, 8'h00, 8'h22};
        void'($urandom(32'd20240611));

        // R1 reset state
        apply_reset(3'd1, 2'd0);
        @(negedge clk);
        check(rst1_n == 1'b1, "R1", "rst1_n after reset", int'(rst1_n), 1);
        check(rst2_n == 1'b1, "R1", "rst2_n after reset", int'(rst2_n), 1);
        chk_en = 1'b1;

        // R2 / R5 / R7: three keys, hold code 1, width code 0
        cur_req = "R2";
        key(8'h11, 1'b1); key(8'h22, 1'b1);
        watch_high(1, 20, "R2");
        key(8'h33, 1'b1);
        measure(1, 1 * 8 + 2, 8 + 1, "R5");
        key(8'h11, 1'b0); key(8'h22, 1'b0); key(8'h33, 1'b0);

        // R3 / R5 immediate hold, R7 wide pulse, channel 2 only
        apply_reset(3'd0, 2'd3);
        cur_req = "R3";
        key(8'h44, 1'b1);
        key(8'h55, 1'b1);
        measure(2, 2, 4 * 8 + 1, "R7");
        check(rst1_n == 1'b1, "R3", "rst1_n untouched by ch2", int'(rst1_n), 1);
        key(8'h44, 1'b0); key(8'h55, 1'b0);

        // R6 drop during qualification restarts the hold
        apply_reset(3'd3, 2'd1);
        cur_req = "R6";
        key(8'h44, 1'b1); key(8'h55, 1'b1);
        repeat (10) @(negedge clk);
        key(8'h55, 1'b0);
        repeat (3) @(negedge clk);
        key(8'h55, 1'b1);
        measure(2, 3 * 8 + 2, 2 * 8 + 1, "R6");

        // R8 long hold gives one pulse, re-press gives another
        cur_req = "R8";
        pulses = 0; prev = rst2_n;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (prev && !rst2_n) pulses++;
            prev = rst2_n;
        end
        check(pulses == 0, "R8", "extra pulses during long hold", pulses, 0);
        key(8'h44, 1'b0);
        key(8'h44, 1'b1);
        measure(2, 3 * 8 + 2, 2 * 8 + 1, "R8");
        key(8'h44, 1'b0); key(8'h55, 1'b0);

        // R4 unused slot on ch1, all-zero ch2, code 0 events
        c1c = 8'h00; c2a = 8'h00; c2b = 8'h00;
        apply_reset(3'd1, 2'd0);
        cur_req = "R4";
        key(8'h00, 1'b1);
        key(8'h11, 1'b1);
        key(8'h22, 1'b1);
        measure(1, 1 * 8 + 2, 8 + 1, "R4");
        watch_high(2, 30, "R4");
        key(8'h11, 1'b0); key(8'h22, 1'b0); key(8'h00, 1'b0);
        c1c = 8'h33; c2a = 8'h44; c2b = 8'h55;

        // R10 unrelated codes and invalid events do not change the match
        apply_reset(3'd1, 2'd0);
        cur_req = "R10";
        key(8'h11, 1'b1); key(8'h22, 1'b1); key(8'h99, 1'b1);
        @(negedge clk);
        ev_valid = 1'b0; ev_code = 8'h33; ev_press = 1'b1;
        watch_high(1, 30, "R10");
        key(8'h99, 1'b0);
        key(8'h33, 1'b1);
        measure(1, 1 * 8 + 2, 8 + 1, "R10");
        key(8'h11, 1'b0); key(8'h22, 1'b0); key(8'h33, 1'b0);

        // R9 pass-through
        cur_req = "R9";
        @(negedge clk); pass_en = 1'b1; ext_rst_n = 1'b0;
        @(negedge clk);
        check(rst1_n == 1'b0, "R9", "rst1_n with pass on", int'(rst1_n), 0);
        check(rst2_n == 1'b1, "R9", "rst2_n with pass on", int'(rst2_n), 1);
        pass_en = 1'b0;
        @(negedge clk);
        check(rst1_n == 1'b1, "R9", "rst1_n with pass off", int'(rst1_n), 1);
        ext_rst_n = 1'b1;

        // Random segments checked cycle by cycle against the model
        cur_req = "R2 R3 R5 R6 R7 R9 random";
        for (int seg = 0; seg < 8; seg++) begin
            c1c = ($urandom_range(0, 2) == 0) ? 8'h00 : 8'h33;
            apply_reset(3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)));
            for (int cyc = 0; cyc < 3000; cyc++) begin
                @(negedge clk);
                ev_valid = ($urandom_range(0, 5) == 0);
                ev_code = pool[$urandom_range(0, 7)];
                ev_press = ($urandom_range(0, 2) != 0);
                pass_en = ($urandom_range(0, 15) == 0);
                ext_rst_n = ($urandom_range(0, 3) != 0);
            end
            @(negedge clk);
            ev_valid = 1'b0; pass_en = 1'b0; ext_rst_n = 1'b1;
        end

        @(negedge clk);
        summary();
        $finish;
    end
endmodule